// File: doc/BRIEF.md
# Fractional SPI Serial Clock Generator

This block derives the serial clock of one SPI profile from a faster reference clock. It does not count down an integer divisor. Each reference cycle it adds a programmable increment to a 12-bit phase accumulator, and every carry out of the accumulator flips the serial clock. Two carries make one serial period, so the output rate is a fraction of the reference rate. An increment of 2048 gives one quarter of the reference rate. A doubling flag multiplies the increment by two.

Each time the serial clock changes, the block emits one-cycle strobes for a neighbouring shift engine. The launch strobe tells it when to drive the next outgoing bit, and the latch strobe tells it when to sample the incoming bit. Each strobe is tied to a rising or a falling serial edge by its own select bit.

The transaction engine controls the block with two inputs. A run enable starts and stops the clock. A loop-start pulse, when the control word asks for it, clears the accumulator so that every transfer loop begins from the same phase.

Top module: `frac_sclk_gen`

## Requirements
- R1: While `runEn` is low, and in the cycle after reset, `sclk` equals `clkPolarity`, both strobes are low, and the accumulator is zero. After enable, the first `sclk` change therefore comes after ceil(4096 / effective increment) enabled cycles.
- R2: The increment is `clkCtrl[13:0]`. Every enabled cycle the 12-bit accumulator adds the effective increment. When the sum reaches 4096 or more, `sclk` flips and the accumulator keeps the sum modulo 4096.
- R3: With an increment of 2048 and no doubling, `sclk` changes every 2 reference cycles, which is a serial period of 4 reference cycles.
- R4: When `clkCtrl[14]` is 1, the effective increment is twice `clkCtrl[13:0]`. An increment of 2048 then flips `sclk` on every reference cycle.
- R5: When `loopStart` is high while enabled and `clkCtrl[15]` is 1, the accumulator clears, `sclk` returns to its idle level, and no strobe fires. When `clkCtrl[15]` is 0, `loopStart` has no effect.
- R6: The idle level of `sclk` is `clkPolarity`: `sclk` = `clkPolarity` XOR the internal phase, where phase 0 is idle.
- R7: `launchStb` is high in exactly the cycles in which `sclk` has just taken a new level equal to `launchRising`. A value of 1 selects rising edges and 0 selects falling edges.
- R8: `latchStb` is high in exactly the cycles in which `sclk` has just taken a new level equal to `latchRising`. This choice is independent of the launch choice.
- R9: Each strobe is one reference cycle wide and appears in the same cycle as the `sclk` change it marks.
- R10: When the effective increment is 4096 or more, `sclk` changes at most once per cycle and the accumulator keeps the sum modulo 4096.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| runEn | input | 1 | Runs the generator; low holds it idle |
| loopStart | input | 1 | Start-of-loop pulse from the transaction engine |
| clkCtrl | input | 16 | Bit 15 loop clear, bit 14 doubling, bits 13:0 increment |
| clkPolarity | input | 1 | Idle level of the serial clock |
| launchRising | input | 1 | 1: launch on rising serial edges; 0: on falling |
| latchRising | input | 1 | 1: latch on rising serial edges; 0: on falling |
| sclk | output | 1 | Serial clock |
| launchStb | output | 1 | One-cycle launch strobe |
| latchStb | output | 1 | One-cycle latch strobe |

## Verification
The bench targets the carry boundary. An off-by-one compare there would move the first edge after enable, and it would turn the 2048 case into a period of 2 or 6 cycles. It also drives increments of 4096 and above through the doubling path, where a narrowed adder would wrap and drop edges. The loop-clear pulse is applied with the clear flag both set and cleared. A design that ignored the flag would either leave the phase where it was or reset it without being asked. Both edge-select combinations and both polarities are run, so a strobe tied to the wrong edge, or a strobe that ignores polarity, differs from the reference model in the first serial period.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;
  // Control-to-datapath strobes, valid for one reference cycle
  typedef struct packed {
    logic toggle;  // accumulator produced a carry this cycle
    logic clear;   // force the phase and strobes back to idle
  } fclkCtl_t;
endpackage

// File: rtl/frac_sclk_ctrl.sv
module frac_sclk_ctrl
  import fracclk_pkg::*;
#(
  parameter int ACC_W   = 12,
  parameter int CTRL_W  = 16,
  parameter int DBL_BIT = 14,
  parameter int RST_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              loopStart,
  input  logic [CTRL_W-1:0] clkCtrl,
  output fclkCtl_t          ctl
);
  localparam int INC_W = DBL_BIT;
  localparam int SUM_W = INC_W + 2;

  logic [ACC_W-1:0] accQ;
  logic [SUM_W-1:0] effInc;
  logic [SUM_W-1:0] sum;
  logic             doClear;
  logic             dblSel;
  logic             rstOnLoop;

  assign dblSel    = clkCtrl[DBL_BIT];
  assign rstOnLoop = clkCtrl[RST_BIT];

  always_comb begin
    if (dblSel) effInc = {1'b0, clkCtrl[INC_W-1:0], 1'b0};
    else        effInc = {2'b00, clkCtrl[INC_W-1:0]};
    sum        = SUM_W'(accQ) + effInc;
    doClear    = !runEn || (loopStart && rstOnLoop);
    ctl.clear  = doClear;
    ctl.toggle = !doClear && (|sum[SUM_W-1:ACC_W]);
  end

  always_ff @(posedge clk) begin
    if (!rstN || doClear) accQ <= '0;
    else                  accQ <= sum[ACC_W-1:0];
  end

  // Loop-start clear leaves the accumulator at zero (R5)
  assert_loop_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(runEn && loopStart && rstOnLoop) |-> accQ == '0);

  // Disabled cycles leave the accumulator at zero (R1)
  assert_idle_acc_R1: assert property (@(posedge clk) disable iff (!rstN)
    !$past(runEn) |-> accQ == '0);
endmodule

// File: rtl/frac_sclk_edge.sv
module frac_sclk_edge
  import fracclk_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  fclkCtl_t ctl,
  input  logic     clkPolarity,
  input  logic     launchRising,
  input  logic     latchRising,
  output logic     sclk,
  output logic     launchStb,
  output logic     latchStb
);
  logic phaseQ;
  logic nextLevel;

  assign nextLevel = ~phaseQ ^ clkPolarity;
  assign sclk      = phaseQ ^ clkPolarity;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      phaseQ    <= 1'b0;
      launchStb <= 1'b0;
      latchStb  <= 1'b0;
    end else if (ctl.toggle) begin
      phaseQ    <= ~phaseQ;
      launchStb <= (nextLevel == launchRising);
      latchStb  <= (nextLevel == latchRising);
    end else begin
      launchStb <= 1'b0;
      latchStb  <= 1'b0;
    end
  end

  // A strobe always coincides with a phase change (R9)
  assert_launch_on_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |-> phaseQ != $past(phaseQ));
  assert_latch_on_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |-> phaseQ != $past(phaseQ));

  // Launch strobe sits on the selected level while polarity is steady (R7)
  assert_launch_level_R7: assert property (@(posedge clk) disable iff (!rstN)
    (launchStb && $stable(clkPolarity) && $stable(launchRising)) |-> sclk == launchRising);

  // Successive launch strobes cannot be adjacent (R9)
  assert_launch_width_R9: assert property (@(posedge clk) disable iff (!rstN)
    launchStb |=> !launchStb);

  // After a clear the phase is idle and strobes are quiet (R1)
  assert_clear_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctl.clear) |-> (!phaseQ && !launchStb && !latchStb));
endmodule

// File: rtl/frac_sclk_gen.sv
module frac_sclk_gen
  import fracclk_pkg::*;
#(
  parameter int ACC_W   = 12,
  parameter int CTRL_W  = 16,
  parameter int DBL_BIT = 14,
  parameter int RST_BIT = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic              loopStart,
  input  logic [CTRL_W-1:0] clkCtrl,
  input  logic              clkPolarity,
  input  logic              launchRising,
  input  logic              latchRising,
  output logic              sclk,
  output logic              launchStb,
  output logic              latchStb
);
  fclkCtl_t ctl;

  frac_sclk_ctrl #(
    .ACC_W(ACC_W), .CTRL_W(CTRL_W), .DBL_BIT(DBL_BIT), .RST_BIT(RST_BIT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .loopStart(loopStart),
    .clkCtrl(clkCtrl), .ctl(ctl)
  );

  frac_sclk_edge u_edge (
    .clk(clk), .rstN(rstN), .ctl(ctl), .clkPolarity(clkPolarity),
    .launchRising(launchRising), .latchRising(latchRising),
    .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
  );
endmodule

// File: tb/frac_sclk_gen_tb.sv
module frac_sclk_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic        loopStart = 1'b0;
  logic [15:0] clkCtrl = 16'h0;
  logic        clkPolarity = 1'b0;
  logic        launchRising = 1'b0;
  logic        latchRising = 1'b1;
  logic        sclk, launchStb, latchStb;

  int    nChecks = 0;
  int    nFails = 0;
  int    cycles = 0;
  string curReq = "R1";

  // behavioural reference state
  int mAcc = 0;
  int mPh = 0;
  int mLaunch = 0;
  int mLatch = 0;

  always #2.5 clk = ~clk;

  frac_sclk_gen u_dut (
    .clk(clk), .rstN(rstN), .runEn(runEn), .loopStart(loopStart),
    .clkCtrl(clkCtrl), .clkPolarity(clkPolarity), .launchRising(launchRising),
    .latchRising(latchRising), .sclk(sclk), .launchStb(launchStb), .latchStb(latchStb)
  );

  always @(posedge clk) begin
    int eff, s, lvl;
    cycles = cycles + 1;
    if (!rstN || !runEn || (loopStart && clkCtrl[15])) begin
      mAcc = 0; mPh = 0; mLaunch = 0; mLatch = 0;
    end else begin
      eff = int'(clkCtrl[13:0]) * (clkCtrl[14] ? 2 : 1);
      s = mAcc + eff;
      if (s >= 4096) begin
        mPh = 1 - mPh;
        lvl = mPh ^ int'(clkPolarity);
        mLaunch = (lvl == int'(launchRising)) ? 1 : 0;
        mLatch  = (lvl == int'(latchRising)) ? 1 : 0;
      end else begin
        mLaunch = 0; mLatch = 0;
      end
      mAcc = s % 4096;
    end
  end

  task automatic check(string req, string what, int got, int exp);
    nChecks++;
    if (got != exp) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, got, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // one cycle: compare at the falling edge, then hold inputs for the next edge
  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(curReq, "sclk", int'(sclk), mPh ^ int'(clkPolarity));
      check(curReq, "launchStb", int'(launchStb), mLaunch);
      check(curReq, "latchStb", int'(latchStb), mLatch);
    end
  endtask

  initial begin
    int toggles;
    int prev;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "reset sclk", int'(sclk), 0);
    check("R1", "reset strobes", int'(launchStb | latchStb), 0);

    // R3 / R7 / R8: 2048 gives a period of 4
    curReq = "R3";
    clkCtrl = 16'd2048; runEn = 1'b1;
    step(1);
    check("R3", "no edge after 1 cycle", int'(sclk), 0);
    step(1);
    check("R3", "first edge after 2 cycles", int'(sclk), 1);
    check("R8", "latch on rising", int'(latchStb), 1);
    curReq = "R7";
    step(2);
    check("R7", "launch on falling", int'(launchStb), 1);
    step(30);

    // R1 disabled, R6 polarity
    curReq = "R1";
    runEn = 1'b0;
    step(4);
    clkPolarity = 1'b1;
    curReq = "R6";
    step(2);
    check("R6", "idle level follows polarity", int'(sclk), 1);

    // R2 arbitrary increment
    curReq = "R2";
    clkCtrl = 16'd700; runEn = 1'b1;
    step(80);

    // R2 directed carry count: 512 for 64 cycles gives 8 edges
    runEn = 1'b0; clkPolarity = 1'b0;
    step(2);
    clkCtrl = 16'd512; runEn = 1'b1;
    toggles = 0; prev = int'(sclk);
    for (int i = 0; i < 64; i++) begin
      step(1);
      if (int'(sclk) != prev) toggles++;
      prev = int'(sclk);
    end
    check("R2", "edges in 64 cycles at 512", toggles, 8);

    // R4 doubling
    curReq = "R4";
    runEn = 1'b0; step(2);
    clkCtrl = 16'h4000 | 16'd2048; runEn = 1'b1;
    step(1);
    check("R4", "doubled 2048 edges every cycle", int'(sclk), 1);
    step(1);
    check("R4", "doubled 2048 second edge", int'(sclk), 0);
    step(20);

    // R10 wide increments
    curReq = "R10";
    clkCtrl = 16'h4000 | 16'd3000;
    step(40);
    clkCtrl = 16'd9000;
    step(30);

    // R5 loop clear with and without the flag
    curReq = "R5";
    clkCtrl = 16'h8000 | 16'd1000;
    step(7);
    loopStart = 1'b1; step(1); loopStart = 1'b0;
    check("R5", "clear returns to idle", int'(sclk), int'(clkPolarity));
    check("R5", "no strobe on clear", int'(launchStb | latchStb), 0);
    step(20);
    clkCtrl = 16'd1000;
    step(3);
    loopStart = 1'b1; step(1); loopStart = 1'b0;
    step(20);

    // R7 / R8 swapped selects, R9 widths
    curReq = "R9";
    launchRising = 1'b1; latchRising = 1'b0; clkPolarity = 1'b1;
    runEn = 1'b0; step(2);
    clkCtrl = 16'd1500; runEn = 1'b1;
    step(60);
    curReq = "R8";
    launchRising = 1'b1; latchRising = 1'b1;
    step(30);

    finishRun();
  end

  initial begin
    wait (cycles > 100000);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    finishRun();
  end
endmodule